// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps a dynamic memory array alive. It owns the power-up bring-up of the array. It also schedules periodic refresh and generates the strobe pattern for each refresh. Every refresh is a column-strobe-first cycle: the column strobe falls before the row strobe. The array then refreshes the row that its own internal counter selects, so the sequencer never drives an address. Data transfer belongs to the access controller and is outside this block.

After reset the block stays silent for a start-up pause. It then runs a burst of wake-up refresh cycles on its own and raises `init_done`. From then on an interval timer adds one pending refresh per period. Refreshes may be postponed: the pending count saturates at a limit, and `ref_urgent` is raised once that limit is reached. The access controller sees `ref_req` and answers with `ref_gnt` when the memory bus is free. The controller also reports its own row-strobe activity on `host_ras_act`. If neither the host nor the sequencer has pulsed the row strobe for a long stretch, the block drops `init_done` and repeats the wake-up burst before handing the bus back.

All times are parameters counted in clock cycles:

| Parameter | Meaning |
|---|---|
| `PAUSE_CYC` | start-up pause |
| `WAKE_CYCLES` | length of the wake-up burst |
| `REF_PERIOD` | refresh interval |
| `POSTPONE_MAX` | pending limit |
| `IDLE_LIMIT` | inactivity limit |
| `T_CSR` | column-strobe lead before the row strobe falls |
| `T_CHR` | column-strobe hold after the row strobe falls |
| `T_RAS` | row-strobe low width, must exceed `T_CHR` |
| `T_RP` | minimum precharge |

Each refresh cycle occupies the strobes for 1 + T_CSR + T_RAS + T_RP cycles.

Top module: `rfs_cbr_init_seq`

## Requirements
- R1: While reset is asserted, `row_strobe_n` and `col_strobe_n` are 1, and `init_done`, `ref_req`, `ref_urgent` and `refresh_active` are 0.
- R2: The strobes stay at 1 for PAUSE_CYC cycles after reset is released. The first column-strobe fall appears on clock edge PAUSE_CYC+1, counting the first edge with reset released as edge 1.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles run back to back without any grant. `init_done` rises on edge PAUSE_CYC + WAKE_CYCLES*(1+T_CSR+T_RAS+T_RP), at a moment when both strobes are 1.
- R4: In every refresh cycle the column strobe is low for exactly T_CSR cycles before the row strobe falls. The column strobe then stays low for exactly T_CHR cycles with the row strobe low. The row strobe stays low for exactly T_RAS cycles.
- R5: Between two row-strobe pulses the row strobe is high for at least T_RP cycles.
- R6: `ref_req` rises exactly REF_PERIOD cycles after `init_done` rises. While grants are continuous, refreshes complete at one per REF_PERIOD (plus or minus one over a window).
- R7: `ref_urgent` rises exactly POSTPONE_MAX*REF_PERIOD cycles after `init_done` when no grant is given. Further periods are not counted beyond the limit, so one completed refresh clears `ref_urgent`. `ref_urgent` implies `ref_req`.
- R8: After initialisation, a refresh starts only when `ref_req` and `ref_gnt` are both 1. Each completed refresh removes one pending refresh, and `ref_req` returns to 0 when none remain.
- R9: The inactivity timer restarts on any cycle with `host_ras_act` = 1 or with a refresh starting or in progress. After the last such cycle, `init_done` stays 1 for IDLE_LIMIT-1 more edges and falls on the next one. Exactly WAKE_CYCLES refresh cycles then run, and `init_done` rises again WAKE_CYCLES*(1+T_CSR+T_RAS+T_RP) edges after it fell.
- R10: `refresh_active` is 1 whenever either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_ras_act | input | 1 | access controller drove its row strobe this cycle |
| ref_gnt | input | 1 | access controller yields the strobes for one refresh |
| ref_req | output | 1 | at least one refresh pending |
| ref_urgent | output | 1 | pending count at the postponement limit |
| refresh_active | output | 1 | sequencer currently owns the strobes |
| row_strobe_n | output | 1 | active-low row strobe during refresh |
| col_strobe_n | output | 1 | active-low column strobe during refresh |
| init_done | output | 1 | array initialised; normal access allowed |

## Verification
The bench builds the block with:

| Parameter | Bench value |
|---|---|
| PAUSE_CYC | 40 |
| WAKE_CYCLES | 8 |
| REF_PERIOD | 20 |
| POSTPONE_MAX | 8 |
| IDLE_LIMIT | 120 |
| T_CSR | 2 |
| T_CHR | 3 |
| T_RAS | 5 |
| T_RP | 3 |

With these values one refresh cycle takes 11 clocks. Start-up completes at edge 128, saturation of the pending count arrives within 220 cycles, and an inactivity re-initialisation fits in a few hundred more. Every pulse in the run has its strobe widths measured. The exact edges of the pause end, the `init_done` rise, the first request, urgency, the inactivity timeout and the re-initialisation are all computed from the parameters. The default values, on the order of 500 µs and 64 ms, are reached only through the same counters at larger widths.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // top-level sequencing state
    typedef enum logic [1:0] {
        SEQ_PAUSE,
        SEQ_WAKE,
        SEQ_RUN
    } seq_state_e;

    // phases of one column-first refresh cycle
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSET,
        PH_HOLD,
        PH_RASLO,
        PH_PRECH
    } cbr_phase_e;

endpackage

// File: rtl/rfs_cbr_gen.sv
module rfs_cbr_gen
    import rfs_pkg::*;
#(
    parameter int T_CSR = 2,
    parameter int T_CHR = 2,
    parameter int T_RAS = 7,
    parameter int T_RP  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic row_n,
    output logic col_n
);
    localparam int MAXT = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int CW = $clog2(MAXT + 1);

    typedef struct packed {
        cbr_phase_e     ph;
        logic [CW-1:0]  cnt;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph  = PH_CSET;
                    d.cnt = CW'(T_CSR - 1);
                end
            end
            PH_CSET: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_HOLD;
                    d.cnt = CW'(T_CHR - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_RASLO;
                    d.cnt = CW'(T_RAS - T_CHR - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_RASLO: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_PRECH;
                    d.cnt = CW'(T_RP - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_PRECH: begin
                if (q.cnt == '0) begin
                    d.ph = PH_IDLE;
                    done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph  <= PH_IDLE;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    // strobes decoded from the registered phase only
    assign busy  = (q.ph != PH_IDLE);
    assign col_n = !((q.ph == PH_CSET) || (q.ph == PH_HOLD));
    assign row_n = !((q.ph == PH_HOLD) || (q.ph == PH_RASLO));

endmodule

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int PERIOD = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == W'(PERIOD - 1));
        if (!en || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rfs_pending.sv
module rfs_pending #(
    parameter int MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic req,
    output logic urgent
);
    localparam int W = $clog2(MAX + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pend_t;

    pend_t q, d;
    logic [W:0] sum;

    always_comb begin
        d   = q;
        sum = {1'b0, q.cnt} + (W+1)'(inc) - (W+1)'(dec);
        if (sum > (W+1)'(MAX)) begin
            d.cnt = W'(MAX);
        end else begin
            d.cnt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign req    = (q.cnt != '0);
    assign urgent = (q.cnt == W'(MAX));

endmodule

// File: rtl/rfs_idle_watch.sv
module rfs_idle_watch #(
    parameter int LIMIT = 8000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic act,
    output logic timeout
);
    localparam int W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } idle_t;

    idle_t q, d;

    always_comb begin
        d       = q;
        timeout = en && !act && (q.cnt == W'(LIMIT - 1));
        if (!en || act) begin
            d.cnt = '0;
        end else if (q.cnt != W'(LIMIT - 1)) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rfs_cbr_init_seq.sv
module rfs_cbr_init_seq
    import rfs_pkg::*;
#(
    parameter int PAUSE_CYC    = 62500,
    parameter int WAKE_CYCLES  = 8,
    parameter int REF_PERIOD   = 1950,
    parameter int POSTPONE_MAX = 8,
    parameter int IDLE_LIMIT   = 8000000,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 2,
    parameter int T_RAS        = 7,
    parameter int T_RP         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_ras_act,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic refresh_active,
    output logic row_strobe_n,
    output logic col_strobe_n,
    output logic init_done
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        seq_state_e     state;
        logic [PW-1:0]  pause_cnt;
        logic [WW-1:0]  wake_cnt;
    } seq_t;

    seq_t q, d;

    logic start, busy, done, tick, timeout, act, dec, running;

    always_comb begin
        d     = q;
        start = 1'b0;
        unique case (q.state)
            SEQ_PAUSE: begin
                if (q.pause_cnt == PW'(PAUSE_CYC - 1)) begin
                    d.state    = SEQ_WAKE;
                    d.wake_cnt = '0;
                end else begin
                    d.pause_cnt = q.pause_cnt + 1'b1;
                end
            end
            SEQ_WAKE: begin
                start = !busy;
                if (done) begin
                    if (q.wake_cnt == WW'(WAKE_CYCLES - 1)) begin
                        d.state    = SEQ_RUN;
                        d.wake_cnt = '0;
                    end else begin
                        d.wake_cnt = q.wake_cnt + 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                start = !busy && ref_gnt && ref_req;
                if (timeout) begin
                    d.state    = SEQ_WAKE;
                    d.wake_cnt = '0;
                end
            end
            default: d.state = SEQ_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= SEQ_PAUSE;
            q.pause_cnt <= '0;
            q.wake_cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign running = (q.state == SEQ_RUN);
    assign dec     = done && running;
    assign act     = host_ras_act || busy || start;

    rfs_cbr_gen #(
        .T_CSR (T_CSR),
        .T_CHR (T_CHR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .row_n (row_strobe_n),
        .col_n (col_strobe_n)
    );

    rfs_tick_gen #(
        .PERIOD (REF_PERIOD)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .tick  (tick)
    );

    rfs_pending #(
        .MAX (POSTPONE_MAX)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick),
        .dec    (dec),
        .req    (ref_req),
        .urgent (ref_urgent)
    );

    rfs_idle_watch #(
        .LIMIT (IDLE_LIMIT)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running),
        .act     (act),
        .timeout (timeout)
    );

    assign refresh_active = busy;
    assign init_done      = running;

endmodule

// File: rtl/rfs_cbr_init_seq_chk.sv
module rfs_cbr_init_seq_chk #(
    parameter int PAUSE_CYC = 62500,
    parameter int T_RP      = 5
) (
    input logic clk,
    input logic rst_n,
    input logic row_n,
    input logic col_n,
    input logic req,
    input logic urgent,
    input logic init_done
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int HW = $clog2(T_RP + 1);

    logic [PW-1:0] since_rst;
    logic [HW-1:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            high_run  <= HW'(T_RP);
        end else begin
            if (since_rst != PW'(PAUSE_CYC)) since_rst <= since_rst + 1'b1;
            if (!row_n)                       high_run  <= '0;
            else if (high_run != HW'(T_RP))   high_run  <= high_run + 1'b1;
        end
    end

    // R2
    quiet_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PW'(PAUSE_CYC)) |-> (row_n && col_n));

    // R4
    col_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_n) |-> (!col_n && !$past(col_n)));

    // R5
    precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_n) |-> (high_run >= HW'(T_RP)));

    // R7
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> req);

    // R8
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_n) |-> ($past(req) || !$past(init_done)));

    // R3
    handoff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (row_n && col_n));

endmodule

bind rfs_cbr_init_seq rfs_cbr_init_seq_chk #(
    .PAUSE_CYC (PAUSE_CYC),
    .T_RP      (T_RP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_n     (row_strobe_n),
    .col_n     (col_strobe_n),
    .req       (ref_req),
    .urgent    (ref_urgent),
    .init_done (init_done)
);

// File: tb/rfs_cbr_init_seq_bench.sv
module rfs_cbr_init_seq_bench;
    localparam int PAUSE = 40;
    localparam int WAKE  = 8;
    localparam int PER   = 20;
    localparam int PMAX  = 8;
    localparam int IDLE  = 120;
    localparam int CSR   = 2;
    localparam int CHR   = 3;
    localparam int RAS   = 5;
    localparam int RP    = 3;
    localparam int CLEN  = 1 + CSR + RAS + RP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_act = 1'b0;
    logic gnt = 1'b0;
    logic req, urg, active, row_n, col_n, idone;

    always #4 clk = ~clk;

    rfs_cbr_init_seq #(
        .PAUSE_CYC (PAUSE), .WAKE_CYCLES (WAKE), .REF_PERIOD (PER),
        .POSTPONE_MAX (PMAX), .IDLE_LIMIT (IDLE),
        .T_CSR (CSR), .T_CHR (CHR), .T_RAS (RAS), .T_RP (RP)
    ) u_rfs_cbr_init_seq (
        .clk (clk), .rst_n (rst_n), .host_ras_act (host_act), .ref_gnt (gnt),
        .ref_req (req), .ref_urgent (urg), .refresh_active (active),
        .row_strobe_n (row_n), .col_strobe_n (col_n), .init_done (idone)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    // grant as seen by the design at each rising edge
    logic gnt_s = 1'b0;
    always @(posedge clk) gnt_s <= gnt;

    // pulse monitor
    int falls = 0, setup_c = 0, low_c = 0, hold_c = 0, high_c = 0;
    int pulses = 0, r8_bad = 0, act_bad = 0;
    bit seen_rise = 1'b0;
    logic p_row = 1'b1, p_col = 1'b1, p_req = 1'b0, p_idone = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_col && !col_n && p_idone && (!p_req || !gnt_s)) r8_bad++;   // R8
            if ((!row_n || !col_n) && !active) act_bad++;                     // R10
            if (p_row && !row_n) begin
                falls++;
                chk(setup_c == CSR, "R4 column lead", setup_c, CSR);
                if (seen_rise) chk(high_c >= RP, "R5 precharge", high_c, RP);
                setup_c = 0; low_c = 0; hold_c = 0;
            end
            if (!p_row && row_n) begin
                pulses++;
                chk(low_c == RAS, "R4 row low width", low_c, RAS);
                chk(hold_c == CHR, "R4 column hold", hold_c, CHR);
                seen_rise = 1'b1;
                high_c = 0; setup_c = 0;
            end
            if (row_n) begin
                high_c++;
                if (!col_n) setup_c++;
            end else begin
                low_c++;
                if (!col_n) hold_c++;
            end
        end
        p_row = row_n; p_col = col_n; p_req = req; p_idone = idone;
    end

    int tcount = 0;
    bit keep = 1'b0;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tcount++;
            host_act = (keep && (tcount % 40 == 0));
        end
    endtask

    initial begin
        int k, first_fall, f0;
        logic pc;
        repeat (3) @(negedge clk);
        chk(row_n == 1'b1, "R1 row strobe", row_n, 1);
        chk(col_n == 1'b1, "R1 column strobe", col_n, 1);
        chk(idone == 1'b0, "R1 init_done", idone, 0);
        chk(req == 1'b0 && urg == 1'b0, "R1 request", {req, urg}, 0);
        chk(active == 1'b0, "R1 refresh_active", active, 0);

        rst_n = 1'b1;
        k = 0; first_fall = -1; pc = 1'b1;
        while (!idone && k < 5000) begin
            @(negedge clk);
            k++;
            if (first_fall < 0 && pc && !col_n) first_fall = k;
            pc = col_n;
        end
        chk(first_fall == PAUSE + 1, "R2 end of pause", first_fall, PAUSE + 1);
        chk(k == PAUSE + WAKE * CLEN, "R3 init_done edge", k, PAUSE + WAKE * CLEN);
        chk(falls == WAKE, "R3 wake-up count", falls, WAKE);
        chk(req == 1'b0, "R6 no request at hand-off", req, 0);

        // interval and postponement, no grant
        keep = 1'b1;
        step(PER - 1);
        chk(req == 1'b0, "R6 request before period", req, 0);
        step(1);
        chk(req == 1'b1, "R6 request at period", req, 1);
        step(PMAX * PER - PER - 1);
        chk(urg == 1'b0, "R7 urgent before limit", urg, 0);
        step(1);
        chk(urg == 1'b1, "R7 urgent at limit", urg, 1);
        step(3 * PER);
        chk(urg == 1'b1 && req == 1'b1, "R7 still urgent", urg, 1);

        // one refresh right after a tick: saturation means urgency clears
        gnt = 1'b1;
        step(1);
        gnt = 1'b0;
        step(CLEN);
        chk(urg == 1'b0, "R7 saturated count", urg, 0);
        chk(req == 1'b1, "R8 one refresh removes one", req, 1);

        // drain, then sustained rate
        gnt = 1'b1;
        k = 0;
        while (req && k < 2000) begin
            step(1);
            k++;
        end
        chk(req == 1'b0, "R8 drained", req, 0);
        f0 = falls;
        step(20 * PER);
        chk((falls - f0) >= 19 && (falls - f0) <= 21, "R6 sustained rate", falls - f0, 20);

        // inactivity re-initialisation
        gnt = 1'b0;
        keep = 1'b0;
        step(2 * CLEN);
        chk(active == 1'b0, "R8 no refresh without grant", active, 0);
        @(negedge clk); host_act = 1'b1;
        @(negedge clk); host_act = 1'b0;
        repeat (IDLE - 1) @(negedge clk);
        chk(idone == 1'b1, "R9 before timeout", idone, 1);
        @(negedge clk);
        chk(idone == 1'b0, "R9 at timeout", idone, 0);
        f0 = falls;
        k = 0;
        while (!idone && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(k == WAKE * CLEN, "R9 re-init length", k, WAKE * CLEN);
        chk(falls - f0 == WAKE, "R9 re-init count", falls - f0, WAKE);

        step(5);
        chk(r8_bad == 0, "R8 grant gating", r8_bad, 0);
        chk(act_bad == 0, "R10 refresh_active", act_bad, 0);
        chk(pulses > 40, "R4 pulses measured", pulses, 41);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule